// File: doc/BRIEF.md
# 1-Wire Slave ROM Command Layer

This block is the network-layer controller of a 1-Wire slave. It sits between a bit-slot layer and a device function layer. The slot layer reports each reset it detects, and whether its low time was long. It also reports each bit the master writes and each slot the master reads. For each read slot the block answers with the bit to put on the line.

After every reset the block collects a command byte and decodes the seven network commands. It can stream out its 64-bit identity, compare a 64-bit address sent by the master, or take part in a search by bit triplets. It keeps two flags. The resume flag lets a previously addressed slave be reselected cheaply. The overdrive flag tells the slot layer to use fast timing.

When a command completes successfully, the block pulses a select strobe for one cycle. From then until the next reset it hands every slot to the function layer. The identity, including its family byte and check byte, is an input supplied already computed.

Top module: `owrom_net`

## Requirements
- R1: After `rst_n` is released, `od_mode`, `fn_sel` and `fn_active` are 0 and `rd_bit` is 1. Bits written before the first reset event are ignored, so a full Skip code (CCh) sent then produces no select.
- R2: After a reset event the block shifts in an 8-bit command, least significant bit first. Skip (CCh) raises `fn_sel` for exactly one cycle, starting the cycle after the eighth bit. `fn_active` is then 1 until the next reset event.
- R3: Read (33h) answers 64 read slots with `id_code[0]` through `id_code[63]` in that order, then raises `fn_sel`.
- R4: Match (55h) reads 64 bits, `id_code[0]` first. If every bit is equal, it raises `fn_sel` after the 64th bit and sets the resume flag.
- R5: During Match, the first bit that differs from `id_code` sends the block idle: no select follows, `rd_bit` stays 1, and later bits are ignored until a reset.
- R6: Search (F0h) handles each identity bit, lowest first, in three slots. The first read slot returns the bit, the second read slot returns its complement, and the third slot writes the master's choice. After all 64 triplets match, the block raises `fn_sel` and sets the resume flag.
- R7: In Search, a chosen bit that differs from the identity bit sends the block idle until a reset. Further read slots return 1.
- R8: Read, Match, Search, Skip, Overdrive Skip and Overdrive Match clear the resume flag as soon as their command byte is decoded.
- R9: Resume (A5h) raises `fn_sel` when the resume flag is set. Otherwise the block idles until a reset.
- R10: Overdrive Skip (3Ch) sets `od_mode` when its command byte completes and raises `fn_sel` at the same time.
- R11: Overdrive Match (69h) sets `od_mode` when its command byte completes, then matches 64 bits as in R4. A full match raises `fn_sel` and sets the resume flag.
- R12: A reset event with `rst_long` = 1 clears `od_mode`. A reset event with `rst_long` = 0 leaves `od_mode` unchanged.
- R13: Any other command byte sends the block idle. It produces no select, drives `rd_bit` = 1, and ignores all slots until a reset.
- R14: A reset event in any state drops `fn_active` on the next cycle and returns the block to command reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_evt | input | 1 | One-cycle strobe: the slot layer saw a bus reset |
| rst_long | input | 1 | Qualifies `rst_evt`: the reset low time was long enough to leave overdrive |
| bit_evt | input | 1 | One-cycle strobe: the master wrote a bit |
| bit_val | input | 1 | Value of the written bit, valid with `bit_evt` |
| rd_req | input | 1 | One-cycle strobe: the master read a slot |
| id_code | input | ID_BITS | Identity; bit 0 is sent first, family code in the low byte |
| rd_bit | output | 1 | Bit to drive in the current read slot (1 releases the line) |
| od_mode | output | 1 | Overdrive flag for the slot layer |
| fn_sel | output | 1 | One-cycle select strobe to the function layer |
| fn_active | output | 1 | Function layer owns the slots until the next reset |

## Verification
The bench builds the block with the default `ID_BITS` of 64 and an identity whose low byte is 3Ah. This lets full 64-slot identity reads, matches and searches run to completion. It also allows mismatches at the very first and very last identity position. Because the width is at its default, the last-bit comparison exercises the same counter wrap that a deployed slave uses. A table of command bytes covers every decoded code and several undefined ones. Directed sequences then chain commands across resets, to show how the resume and overdrive flags carry over from one reset to the next.

// File: rtl/owrom_net.sv
`timescale 1ns/1ps
module owrom_net #(
  parameter int ID_BITS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_evt,
  input  logic               rst_long,
  input  logic               bit_evt,
  input  logic               bit_val,
  input  logic               rd_req,
  input  logic [ID_BITS-1:0] id_code,
  output logic               rd_bit,
  output logic               od_mode,
  output logic               fn_sel,
  output logic               fn_active
);
  localparam int IDX_W = $clog2(ID_BITS);
  localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_BITS - 1);
  localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(7);

  localparam logic [7:0] C_READ    = 8'h33;
  localparam logic [7:0] C_MATCH   = 8'h55;
  localparam logic [7:0] C_SEARCH  = 8'hF0;
  localparam logic [7:0] C_SKIP    = 8'hCC;
  localparam logic [7:0] C_RESUME  = 8'hA5;
  localparam logic [7:0] C_ODSKIP  = 8'h3C;
  localparam logic [7:0] C_ODMATCH = 8'h69;

  typedef enum logic [2:0] {S_WAIT, S_CMD, S_TXID, S_MATCH, S_SRCH, S_FUNC} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic [1:0]       ph;
  logic [7:0]       sh;
  logic             rc;

  wire [7:0] cmd_now  = {bit_val, sh[7:1]};
  wire       id_bit   = id_code[idx];
  wire       idx_last = (idx == ID_LAST);

  assign fn_active = (st == S_FUNC);
  assign rd_bit = (st == S_TXID)              ? id_bit  :
                  (st == S_SRCH && ph == 2'd0) ? id_bit  :
                  (st == S_SRCH && ph == 2'd1) ? ~id_bit : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_WAIT;
      idx     <= '0;
      ph      <= '0;
      sh      <= '0;
      rc      <= 1'b0;
      od_mode <= 1'b0;
      fn_sel  <= 1'b0;
    end else begin
      fn_sel <= 1'b0;
      if (rst_evt) begin
        st  <= S_CMD;
        idx <= '0;
        ph  <= '0;
        if (rst_long) od_mode <= 1'b0;
      end else begin
        case (st)
          S_CMD: if (bit_evt) begin
            sh  <= cmd_now;
            idx <= idx + 1'b1;
            if (idx == CMD_LAST) begin
              idx <= '0;
              ph  <= '0;
              case (cmd_now)
                C_READ:   begin rc <= 1'b0; st <= S_TXID; end
                C_MATCH:  begin rc <= 1'b0; st <= S_MATCH; end
                C_SEARCH: begin rc <= 1'b0; st <= S_SRCH; end
                C_SKIP:   begin rc <= 1'b0; st <= S_FUNC; fn_sel <= 1'b1; end
                C_RESUME: begin
                  if (rc) begin st <= S_FUNC; fn_sel <= 1'b1; end
                  else st <= S_WAIT;
                end
                C_ODSKIP: begin
                  rc <= 1'b0; od_mode <= 1'b1; st <= S_FUNC; fn_sel <= 1'b1;
                end
                C_ODMATCH: begin rc <= 1'b0; od_mode <= 1'b1; st <= S_MATCH; end
                default:  st <= S_WAIT;
              endcase
            end
          end
          S_TXID: if (rd_req) begin
            if (idx_last) begin st <= S_FUNC; fn_sel <= 1'b1; end
            else idx <= idx + 1'b1;
          end
          S_MATCH: if (bit_evt) begin
            if (bit_val != id_bit) st <= S_WAIT;
            else if (idx_last) begin rc <= 1'b1; st <= S_FUNC; fn_sel <= 1'b1; end
            else idx <= idx + 1'b1;
          end
          S_SRCH: begin
            if (ph == 2'd0) begin
              if (rd_req) ph <= 2'd1;
            end else if (ph == 2'd1) begin
              if (rd_req) ph <= 2'd2;
            end else if (bit_evt) begin
              ph <= 2'd0;
              if (bit_val != id_bit) st <= S_WAIT;
              else if (idx_last) begin rc <= 1'b1; st <= S_FUNC; fn_sel <= 1'b1; end
              else idx <= idx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_sel_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fn_sel |=> !fn_sel);
  assert_sel_hands_over_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fn_sel |-> fn_active);
  assert_long_reset_clears_od_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && rst_long) |=> !od_mode);
  assert_short_reset_keeps_od_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && !rst_long && od_mode) |=> od_mode);
  assert_reset_aborts_R14: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> !fn_active);
  assert_od_only_on_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(od_mode) |-> $past(bit_evt));
endmodule

// File: tb/tb_owrom_net.sv
`timescale 1ns/1ps
module tb_owrom_net;
  localparam logic [63:0] ID = 64'h5C00_1234_5678_9A3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_evt = 1'b0, rst_long = 1'b0, bit_evt = 1'b0, bit_val = 1'b0, rd_req = 1'b0;
  logic [63:0] id_code = ID;
  wire rd_bit, od_mode, fn_sel, fn_active;

  owrom_net #(.ID_BITS(64)) dut (
    .clk(clk), .rst_n(rst_n), .rst_evt(rst_evt), .rst_long(rst_long),
    .bit_evt(bit_evt), .bit_val(bit_val), .rd_req(rd_req), .id_code(id_code),
    .rd_bit(rd_bit), .od_mode(od_mode), .fn_sel(fn_sel), .fn_active(fn_active));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, sels = 0;
  bit done = 1'b0;

  always @(posedge clk) if (fn_sel) sels <= sels + 1;

  // {command, expected select, expected od_mode} from a fresh long reset with resume clear
  localparam logic [9:0] VEC [10] = '{
    {8'hCC, 1'b1, 1'b0}, {8'h3C, 1'b1, 1'b1}, {8'hA5, 1'b0, 1'b0},
    {8'h33, 1'b0, 1'b0}, {8'h55, 1'b0, 1'b0}, {8'hF0, 1'b0, 1'b0},
    {8'h69, 1'b0, 1'b1}, {8'h00, 1'b0, 1'b0}, {8'hFF, 1'b0, 1'b0},
    {8'h3D, 1'b0, 1'b0}};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_rst(input logic lng);
    @(negedge clk); rst_evt = 1'b1; rst_long = lng;
    @(negedge clk); rst_evt = 1'b0; rst_long = 1'b0;
    @(negedge clk);
  endtask

  task automatic wbit(input logic b);
    @(negedge clk); bit_evt = 1'b1; bit_val = b;
    @(negedge clk); bit_evt = 1'b0; bit_val = 1'b0;
    @(negedge clk);
  endtask

  task automatic wbyte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) wbit(b[i]);
  endtask

  task automatic rbit(output logic b);
    @(negedge clk); b = rd_bit; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R14 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int s0;
    int bad;
    logic b;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 od_mode after reset", od_mode, 0);
    chk("R1 fn_active after reset", fn_active, 0);
    chk("R1 fn_sel after reset", fn_sel, 0);
    chk("R1 rd_bit after reset", rd_bit, 1);
    s0 = sels;
    wbyte(8'hCC);
    chk("R1 no select before first bus reset", sels - s0, 0);
    chk("R1 no hand-over before first bus reset", fn_active, 0);

    foreach (VEC[k]) begin
      pulse_rst(1'b1);
      s0 = sels;
      wbyte(VEC[k][9:2]);
      chk($sformatf("R2 R9 R10 R11 R13 cmd %02h select count", VEC[k][9:2]), sels - s0, VEC[k][1]);
      chk($sformatf("R2 R10 R11 R13 cmd %02h od_mode", VEC[k][9:2]), od_mode, VEC[k][0]);
      chk($sformatf("R2 R13 cmd %02h fn_active", VEC[k][9:2]), fn_active, VEC[k][1]);
    end

    // R13: idle after unknown code drives ones and ignores a later Skip code
    pulse_rst(1'b1);
    wbyte(8'h12);
    rbit(b);
    chk("R13 idle read slot", b, 1);
    s0 = sels;
    wbyte(8'hCC);
    chk("R13 slots ignored until reset", sels - s0, 0);

    // R3: identity read stream
    pulse_rst(1'b1);
    wbyte(8'h33);
    bad = 0;
    s0 = sels;
    for (int i = 0; i < 64; i++) begin
      rbit(b);
      if (b !== ID[i]) bad++;
      if (i == 62) chk("R3 no select before last bit", sels - s0, 0);
    end
    chk("R3 identity bits wrong", bad, 0);
    chk("R3 select after identity", sels - s0, 1);
    chk("R3 hand-over after identity", fn_active, 1);

    // R14: reset from function state and from mid-stream
    pulse_rst(1'b0);
    chk("R14 fn_active dropped by reset", fn_active, 0);
    wbyte(8'h33);
    for (int i = 0; i < 10; i++) rbit(b);
    pulse_rst(1'b0);
    s0 = sels;
    wbyte(8'hCC);
    chk("R14 command accepted after abort", sels - s0, 1);

    // R4 R9: full match then resume
    pulse_rst(1'b1);
    wbyte(8'h55);
    s0 = sels;
    for (int i = 0; i < 64; i++) wbit(ID[i]);
    chk("R4 match select", sels - s0, 1);
    pulse_rst(1'b0);
    s0 = sels;
    wbyte(8'hA5);
    chk("R9 resume with flag set", sels - s0, 1);
    pulse_rst(1'b0);
    s0 = sels;
    wbyte(8'hA5);
    chk("R9 resume repeats while flag set", sels - s0, 1);

    // R8: Skip clears the resume flag
    pulse_rst(1'b0);
    wbyte(8'hCC);
    pulse_rst(1'b0);
    s0 = sels;
    wbyte(8'hA5);
    chk("R8 resume refused after skip", sels - s0, 0);

    // R5: mismatch on last bit, then on first bit
    pulse_rst(1'b1);
    wbyte(8'h55);
    for (int i = 0; i < 64; i++) wbit(20'(i == 63) ^ ID[i]);
    chk("R5 last-bit mismatch no select", fn_active, 0);
    rbit(b);
    chk("R5 idle read slot", b, 1);
    pulse_rst(1'b1);
    wbyte(8'h55);
    s0 = sels;
    wbit(~ID[0]);
    for (int i = 1; i < 64; i++) wbit(ID[i]);
    chk("R5 first-bit mismatch no select", sels - s0, 0);
    pulse_rst(1'b0);
    s0 = sels;
    wbyte(8'hA5);
    chk("R8 resume refused after failed match", sels - s0, 0);

    // R6: full search
    pulse_rst(1'b1);
    wbyte(8'hF0);
    bad = 0;
    s0 = sels;
    for (int i = 0; i < 64; i++) begin
      rbit(b); if (b !== ID[i]) bad++;
      rbit(b); if (b !== ~ID[i]) bad++;
      wbit(ID[i]);
    end
    chk("R6 search triplet bits wrong", bad, 0);
    chk("R6 search select", sels - s0, 1);
    pulse_rst(1'b0);
    s0 = sels;
    wbyte(8'hA5);
    chk("R6 search sets resume flag", sels - s0, 1);

    // R7: search drops out on bit 5
    pulse_rst(1'b1);
    wbyte(8'hF0);
    for (int i = 0; i < 5; i++) begin rbit(b); rbit(b); wbit(ID[i]); end
    rbit(b); rbit(b); wbit(~ID[5]);
    rbit(b);
    chk("R7 dropped-out read slot", b, 1);
    rbit(b);
    chk("R7 dropped-out second read slot", b, 1);
    chk("R7 no hand-over", fn_active, 0);

    // R11 R12: overdrive match, short reset keeps speed, long reset clears
    pulse_rst(1'b1);
    wbyte(8'h69);
    chk("R11 od_mode after command byte", od_mode, 1);
    s0 = sels;
    for (int i = 0; i < 64; i++) wbit(ID[i]);
    chk("R11 overdrive match select", sels - s0, 1);
    pulse_rst(1'b0);
    chk("R12 short reset keeps od_mode", od_mode, 1);
    s0 = sels;
    wbyte(8'hA5);
    chk("R11 resume after overdrive match", sels - s0, 1);
    pulse_rst(1'b1);
    chk("R12 long reset clears od_mode", od_mode, 0);

    // R8 R10: overdrive skip clears resume flag
    pulse_rst(1'b0);
    wbyte(8'h55);
    for (int i = 0; i < 64; i++) wbit(ID[i]);
    pulse_rst(1'b0);
    wbyte(8'h3C);
    chk("R10 overdrive skip od_mode", od_mode, 1);
    pulse_rst(1'b0);
    s0 = sels;
    wbyte(8'hA5);
    chk("R8 resume refused after overdrive skip", sels - s0, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule